// File: doc/BRIEF.md
# Key-Guarded Scan Segment Switch with Tamper Trap

This cell sits in a reconfigurable on-chip scan network. Like an ordinary segment switch it holds one scan bit. When the switch is closed, the serial path runs through that one bit. When it is open, a hidden instrument segment is inserted after the bit, and the path runs through both. The cell adds two protections. First, an open request on the update phase takes effect only if a group of key bits, held elsewhere in the chain, shows a fixed expected pattern in that same update. Second, trap bits are updated alongside the cell. A wrong value in a trap latches a lockout that keeps the switch closed until the next global reset.

A locked cell still looks like a normal one from the outside. It still shifts and captures, and its capture value reports its open state, which is always closed once the trap has tripped. An external tester cannot tell from the scan data whether the trap has fired.

Top module: `lsib_cell`

## Requirements
- R1: While `rst` is high at a clock edge, the cell bit is cleared, the switch is closed and the trap is cleared. After the edge, `seg_open` is 0 and `scan_out` is 0.
- R2: While closed (`seg_open`=0), `scan_out` equals the cell bit, and `seg_si` carries the cell bit to the segment.
- R3: While open (`seg_open`=1), `scan_out` equals `seg_return`, the last bit of the inserted segment.
- R4: On a clock edge with `capture_en`=1, the cell bit loads the current open state (1 = open). Otherwise, with `shift_en`=1, it loads `scan_in`. Capture wins if both are high.
- R5: The switch opens only at an update edge (`update_en`=1) where all of the following hold: the cell bit is 1, `key_upd` equals parameter `KEY_VAL`, every trap bit is 0 and the cell is not trapped.
- R6: An update with cell bit 1 and a wrong key leaves the open or closed state unchanged.
- R7: An update with cell bit 0 closes the switch, whatever the key.
- R8: An update with any trap bit at 1 (the safe value is 0) trips the lock and closes the switch at that edge, even if the key is correct.
- R9: A tripped cell never opens, even with a correct key and cell bit 1. It still shifts, and a capture then loads 0.
- R10: The lockout persists through any shift, capture or update and is cleared only by `rst`. After a reset, a correct key opens the switch again.
- R11: Edges without `update_en` never change the open or closed state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan clock |
| rst | input | 1 | Global synchronous reset, active high |
| capture_en | input | 1 | Capture phase strobe |
| shift_en | input | 1 | Shift phase strobe |
| update_en | input | 1 | Update phase strobe |
| scan_in | input | 1 | Serial data from the previous chain stage |
| seg_return | input | 1 | Serial data returned from the end of the hidden segment |
| key_upd | input | KEY_W | Update values of the key bits elsewhere in the chain |
| trap_upd | input | TRAP_W | Update values of the trap bits |
| seg_si | output | 1 | Serial data into the hidden segment (the cell bit) |
| seg_open | output | 1 | Segment inserted in the path; also the segment's select |
| scan_out | output | 1 | Serial data to the next chain stage |

## Verification
The hardest situation to reach is a cell that has tripped its trap and is then offered a fully correct opening update: cell bit 1, matching key and all traps 0. The stimulus opens the switch first with a valid key. It then issues a single update that carries the correct key together with a trap bit of 1, which must close and lock the switch. Next it shifts a 1 and repeats a clean, correct-key update, which must leave the switch closed. A capture must then read back 0. Only a reset followed by the same correct-key update may open the switch again.

// File: rtl/lsib_pkg.sv
package lsib_pkg;

    typedef enum logic [1:0] {
        ACT_KEEP  = 2'd0,
        ACT_OPEN  = 2'd1,
        ACT_CLOSE = 2'd2,
        ACT_LOCK  = 2'd3
    } upd_act_e;

    typedef struct packed {
        logic is_open;
        logic locked;
    } sw_state_t;

    localparam sw_state_t SW_RESET = '{is_open: 1'b0, locked: 1'b0};

    // Decide the update action; a trip or an existing lockout dominates.
    function automatic upd_act_e pick_action(
        input logic trip,
        input logic locked,
        input logic cell_bit,
        input logic key_ok
    );
        upd_act_e act;
        if (trip || locked)       act = ACT_LOCK;
        else if (!cell_bit)       act = ACT_CLOSE;
        else if (key_ok)          act = ACT_OPEN;
        else                      act = ACT_KEEP;
        return act;
    endfunction

endpackage

// File: rtl/lsib_shift_stage.sv
module lsib_shift_stage (
    input  logic clk,
    input  logic rst,
    input  logic capture_en,
    input  logic shift_en,
    input  logic scan_in,
    input  logic cap_val,
    output logic cell_bit
);
    always_ff @(posedge clk) begin
        if (rst)             cell_bit <= 1'b0;
        else if (capture_en) cell_bit <= cap_val;
        else if (shift_en)   cell_bit <= scan_in;
    end
endmodule

// File: rtl/lsib_key_cmp.sv
module lsib_key_cmp #(
    parameter int                KEY_W   = 8,
    parameter logic [KEY_W-1:0]  KEY_VAL = 8'hA5
) (
    input  logic [KEY_W-1:0] key_upd,
    output logic             key_ok
);
    logic [KEY_W-1:0] bit_hit;

    for (genvar i = 0; i < KEY_W; i++) begin : g_bit
        assign bit_hit[i] = ~(key_upd[i] ^ KEY_VAL[i]);
    end

    assign key_ok = &bit_hit;
endmodule

// File: rtl/lsib_lock_ctrl.sv
module lsib_lock_ctrl
    import lsib_pkg::*;
#(
    parameter int TRAP_W = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              update_en,
    input  logic              cell_bit,
    input  logic              key_ok,
    input  logic [TRAP_W-1:0] trap_upd,
    output sw_state_t         state
);
    localparam logic [TRAP_W-1:0] TRAP_SAFE = '0;

    logic     trip;
    upd_act_e act;

    assign trip = (trap_upd != TRAP_SAFE);
    assign act  = pick_action(trip, state.locked, cell_bit, key_ok);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SW_RESET;
        end else if (update_en) begin
            unique case (act)
                ACT_LOCK:  state <= '{is_open: 1'b0, locked: 1'b1};
                ACT_OPEN:  state.is_open <= 1'b1;
                ACT_CLOSE: state.is_open <= 1'b0;
                default:   state <= state;
            endcase
        end
    end
endmodule

// File: rtl/lsib_cell.sv
module lsib_cell
    import lsib_pkg::*;
#(
    parameter int                KEY_W   = 8,
    parameter logic [KEY_W-1:0]  KEY_VAL = 8'hA5,
    parameter int                TRAP_W  = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              capture_en,
    input  logic              shift_en,
    input  logic              update_en,
    input  logic              scan_in,
    input  logic              seg_return,
    input  logic [KEY_W-1:0]  key_upd,
    input  logic [TRAP_W-1:0] trap_upd,
    output logic              seg_si,
    output logic              seg_open,
    output logic              scan_out
);
    logic      cell_bit;
    logic      key_ok;
    logic      trapped_q;
    sw_state_t sw;

    lsib_shift_stage u_stage (
        .clk        (clk),
        .rst        (rst),
        .capture_en (capture_en),
        .shift_en   (shift_en),
        .scan_in    (scan_in),
        .cap_val    (sw.is_open),
        .cell_bit   (cell_bit)
    );

    lsib_key_cmp #(.KEY_W(KEY_W), .KEY_VAL(KEY_VAL)) u_key (
        .key_upd (key_upd),
        .key_ok  (key_ok)
    );

    lsib_lock_ctrl #(.TRAP_W(TRAP_W)) u_lock (
        .clk       (clk),
        .rst       (rst),
        .update_en (update_en),
        .cell_bit  (cell_bit),
        .key_ok    (key_ok),
        .trap_upd  (trap_upd),
        .state     (sw)
    );

    assign trapped_q = sw.locked;
    assign seg_open  = sw.is_open;
    assign seg_si    = cell_bit;
    assign scan_out  = sw.is_open ? seg_return : cell_bit;
endmodule

// File: rtl/lsib_cell_chk.sv
module lsib_cell_chk #(
    parameter int                KEY_W   = 8,
    parameter logic [KEY_W-1:0]  KEY_VAL = 8'hA5,
    parameter int                TRAP_W  = 1
) (
    input logic              clk,
    input logic              rst,
    input logic              update_en,
    input logic              seg_return,
    input logic [KEY_W-1:0]  key_upd,
    input logic [TRAP_W-1:0] trap_upd,
    input logic              seg_si,
    input logic              seg_open,
    input logic              scan_out,
    input logic              trapped_q
);
    // R2
    closed_path_chk: assert property (@(posedge clk) disable iff (rst)
        !seg_open |-> scan_out == seg_si);

    // R3
    open_path_chk: assert property (@(posedge clk) disable iff (rst)
        seg_open |-> scan_out == seg_return);

    // R5
    open_needs_key_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(seg_open) |-> $past(update_en && seg_si && key_upd == KEY_VAL
                                  && trap_upd == '0 && !trapped_q));

    // R8
    trap_trip_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(update_en && trap_upd != '0) && !$past(rst)) |-> (trapped_q && !seg_open));

    // R9
    trapped_closed_chk: assert property (@(posedge clk) disable iff (rst)
        trapped_q |-> !seg_open);

    // R10
    trap_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(trapped_q) && !$past(rst)) |-> trapped_q);

    // R11
    no_update_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(update_en) && !$past(rst)) |-> $stable(seg_open));
endmodule

bind lsib_cell lsib_cell_chk #(
    .KEY_W   (KEY_W),
    .KEY_VAL (KEY_VAL),
    .TRAP_W  (TRAP_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .update_en  (update_en),
    .seg_return (seg_return),
    .key_upd    (key_upd),
    .trap_upd   (trap_upd),
    .seg_si     (seg_si),
    .seg_open   (seg_open),
    .scan_out   (scan_out),
    .trapped_q  (trapped_q)
);

// File: tb/lsib_cell_test.sv
module lsib_cell_test;
    localparam int         CLK_PERIOD = 10;
    localparam logic [7:0] KEY        = 8'hA5;
    localparam logic [7:0] BADKEY     = 8'h5A;

    typedef struct {
        string req;
        logic  exp_open;
        logic  exp_out;
    } exp_item_t;

    logic       clk = 1'b0;
    logic       rst = 1'b0;
    logic       capture_en = 1'b0;
    logic       shift_en = 1'b0;
    logic       update_en = 1'b0;
    logic       scan_in = 1'b0;
    logic       seg_return = 1'b0;
    logic [7:0] key_upd = '0;
    logic [0:0] trap_upd = '0;
    logic       seg_si;
    logic       seg_open;
    logic       scan_out;

    exp_item_t  sb_q[$];
    int         total = 0;
    int         bad = 0;
    bit         done = 1'b0;

    // bench reference state
    logic m_bit = 1'b0;
    logic m_open = 1'b0;
    logic m_trap = 1'b0;

    lsib_cell #(.KEY_W(8), .KEY_VAL(KEY), .TRAP_W(1)) uut (
        .clk        (clk),
        .rst        (rst),
        .capture_en (capture_en),
        .shift_en   (shift_en),
        .update_en  (update_en),
        .scan_in    (scan_in),
        .seg_return (seg_return),
        .key_upd    (key_upd),
        .trap_upd   (trap_upd),
        .seg_si     (seg_si),
        .seg_open   (seg_open),
        .scan_out   (scan_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // monitor: compare one queued item a few time units after each edge
    initial begin
        forever begin
            @(posedge clk);
            #3;
            if (sb_q.size() > 0) begin
                exp_item_t it;
                it = sb_q.pop_front();
                total++;
                if (seg_open !== it.exp_open || scan_out !== it.exp_out) begin
                    bad++;
                    $display("FAIL %s: open=%b out=%b expected open=%b out=%b",
                             it.req, seg_open, scan_out, it.exp_open, it.exp_out);
                end
            end
        end
    end

    task automatic do_reset(input string req);
        @(negedge clk);
        rst = 1'b1; capture_en = 0; shift_en = 0; update_en = 0;
        @(negedge clk);
        m_bit = 0; m_open = 0; m_trap = 0;
        sb_q.push_back('{req: req, exp_open: 1'b0, exp_out: 1'b0});
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic step(input logic cap, input logic sh, input logic upd,
                        input logic si, input logic [7:0] key,
                        input logic trap, input logic sr, input string req);
        logic n_bit, n_open;
        @(negedge clk);
        capture_en = cap; shift_en = sh; update_en = upd;
        scan_in = si; key_upd = key; trap_upd = trap; seg_return = sr;
        n_bit  = cap ? m_open : (sh ? si : m_bit);
        n_open = m_open;
        if (upd) begin
            if (trap) m_trap = 1'b1;
            if (m_trap)                     n_open = 1'b0;
            else if (!m_bit)                n_open = 1'b0;
            else if (key == KEY)            n_open = 1'b1;
        end
        m_bit  = n_bit;
        m_open = n_open;
        sb_q.push_back('{req: req, exp_open: m_open,
                         exp_out: m_open ? sr : m_bit});
    endtask

    // watchdog
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        do_reset("R1");
        // closed path, shifting
        step(0,1,0, 1, BADKEY, 0, 0, "R2_R4 shift 1");
        step(0,1,0, 0, BADKEY, 0, 1, "R2_R4 shift 0");
        step(0,1,0, 1, BADKEY, 0, 0, "R2 shift 1 again");
        // wrong key: no open
        step(0,0,1, 0, BADKEY, 0, 0, "R6 wrong key stays closed");
        // correct key opens
        step(0,0,1, 0, KEY,    0, 0, "R5 correct key opens");
        step(0,1,0, 0, KEY,    0, 1, "R3_R11 open path returns 1");
        step(0,1,0, 1, KEY,    0, 0, "R3_R11 open path returns 0");
        step(1,0,0, 0, KEY,    0, 1, "R4 capture while open");
        step(0,1,0, 0, KEY,    0, 0, "R11 shift keeps open");
        // cell bit 0 closes without key
        step(0,0,1, 0, BADKEY, 0, 1, "R7 zero closes");
        step(1,0,0, 0, BADKEY, 0, 1, "R4 capture while closed");
        step(0,1,0, 1, BADKEY, 0, 0, "R2 shift 1");
        step(0,0,1, 0, KEY,    0, 0, "R5 reopen");
        step(0,0,1, 0, BADKEY, 0, 1, "R6 wrong key stays open");
        // trap with correct key
        step(0,0,1, 0, KEY,    1, 1, "R8 trap trips and closes");
        step(0,1,0, 1, KEY,    0, 0, "R9 trapped still shifts");
        step(0,0,1, 0, KEY,    0, 1, "R9 correct key blocked");
        step(1,0,0, 0, KEY,    0, 1, "R9 capture reads closed");
        step(0,1,0, 1, KEY,    0, 0, "R9 shift after capture");
        step(0,0,1, 0, KEY,    0, 1, "R10 lock persists");
        // reset clears the lockout
        do_reset("R1_R10 reset");
        step(0,1,0, 1, KEY,    0, 0, "R10 shift 1 after reset");
        step(0,0,1, 0, KEY,    0, 1, "R10 opens after reset");
        step(0,0,0, 0, KEY,    0, 0, "R3 idle open path");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule